// File: doc/BRIEF.md
# Nestable Priority Interrupt Controller

This block arbitrates between 54 interrupt request sources for a processor core. Each source has an enable bit and a 3-bit user level; a pulse on a source's request line sets its pending flag. Every cycle the block selects one pending source as the winner. Among the sources that are enabled and have a nonzero level, the one with the highest level wins. When two or more share that level, the one with the lowest vector number wins. The winner is taken only if its level is strictly above the current CPU level. On a take, the block emits a one-cycle pulse with the vector number and a vector-table address, clears the source's pending flag, pushes the old CPU level onto an internal stack, and raises the CPU level.

A return strobe from the core pops the stack and restores the saved level. A nesting-disable input makes every take raise the CPU level to 7, which blocks all further takes until the return. In that mode, software writes to the CPU level are also ignored. A table-select input chooses between the primary vector table and an alternate table placed 0x80 above it.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the CPU level is 0, `take` is low, and every source has enable 0 and level 0. A request that arrives before any configuration write is never taken.
- R2: A pending source is never taken while its enable is 0 or its level is 0. It stays pending, and is taken once configuration makes it eligible.
- R3: Among eligible pending sources, the one with the highest level wins, whatever its vector number.
- R4: Among eligible pending sources with equal highest level, the lowest vector number wins (vector 0 ranks first, vector 53 last).
- R5: With nesting enabled, the winner is taken only when its level is strictly greater than the CPU level. On a take, the CPU level becomes the winner's level and the old level is pushed onto the stack.
- R6: With nesting disabled, every take sets the CPU level to 7. Levels then serve only to pick among requests that are pending together.
- R7: A CPU level write (`ipl_we`) loads `ipl_wdata` when nesting is enabled. It is ignored while nesting is disabled.
- R8: The vector address is base + 4 + 2 × vector. The base is 0x00 when `alt_sel` = 0 and 0x80 when `alt_sel` = 1; for example, vector 36 gives 0x4C or 0xCC.
- R9: A return strobe restores the most recently pushed level. A return with an empty stack leaves the CPU level unchanged.
- R10: A take shows as `take` high for one cycle, two clock edges after the request pulse. That source's pending flag is cleared, so it is not taken again without a new request.
- R11: If a return strobe and an eligible take fall in the same cycle, the return wins. The take is then decided in the next cycle against the restored level.
- R12: If a CPU level write and a take fall in the same cycle, the take's new level wins. The level pushed onto the stack is the one from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_set | input | 54 | Per-source request pulses; each pulse sets that source's pending flag |
| cfg_we | input | 1 | Write strobe for one source's configuration |
| cfg_idx | input | 6 | Source number to configure |
| cfg_en | input | 1 | Enable bit to write |
| cfg_lvl | input | 3 | User level to write (0 disables the source) |
| ipl_we | input | 1 | CPU level write strobe |
| ipl_wdata | input | 3 | CPU level write data |
| nest_dis | input | 1 | 1 disables nesting |
| alt_sel | input | 1 | 1 selects the alternate vector table |
| rfi | input | 1 | Return-from-interrupt strobe |
| take | output | 1 | One-cycle pulse: interrupt taken |
| vec_num | output | 6 | Vector number of the taken source |
| vec_addr | output | 16 | Vector-table address of the taken source |
| cpu_lvl | output | 3 | Current CPU priority level |

## Verification
Two pairs of functions can collide in one cycle: a return strobe with a take, and a CPU level write with a take. The first collision is provoked by letting a high-level source become pending one cycle before the return strobe. The bench then expects no take in the strobe cycle, the restored level afterwards, and the take one cycle later. The second collision is provoked by driving a level write in the cycle a take is decided. The bench then expects the winner's level, and after the return it expects the level from before the write. Around these cases, the bench sweeps every source at every level in both tables, every pair of sources at equal level, and level-override pairs.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_TOP = '1;
endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs #(
    parameter int N     = 54,
    parameter int VEC_W = $clog2(N)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [VEC_W-1:0]            idx,
    input  logic                        en_in,
    input  nic_pkg::lvl_t               lvl_in,
    output logic [N-1:0]                en_out,
    output logic [N-1:0][nic_pkg::LVL_W-1:0] lvl_out
);
    typedef struct packed {
        logic [N-1:0]                        en;
        logic [N-1:0][nic_pkg::LVL_W-1:0]    lvl;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (we && (int'(idx) < N)) begin
            c_d.en[idx]  = en_in;
            c_d.lvl[idx] = lvl_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign en_out  = c_q.en;
    assign lvl_out = c_q.lvl;
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
    parameter int N     = 54,
    parameter int VEC_W = $clog2(N)
) (
    input  logic [N-1:0]                     pend,
    input  logic [N-1:0]                     en,
    input  logic [N-1:0][nic_pkg::LVL_W-1:0] lvl,
    output logic                             win_valid,
    output logic [VEC_W-1:0]                 win_idx,
    output nic_pkg::lvl_t                    win_lvl
);
    // Scan from the last vector down; ">=" lets a lower number take over a tie.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i] && en[i] && (lvl[i] != '0) && (lvl[i] >= win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = VEC_W'(i);
                win_lvl   = lvl[i];
            end
        end
    end

    always_comb begin
        if (win_valid) begin
            assert_win_eligible_R2: assert (pend[win_idx] && en[win_idx] && (lvl[win_idx] != '0));
        end
    end
endmodule

// File: rtl/nic_vec_map.sv
module nic_vec_map #(
    parameter int          VEC_W    = 6,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] PRI_BASE = 16'h0000,
    parameter logic [15:0] ALT_OFS  = 16'h0080
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic              alt,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] BASE_P = ADDR_W'(PRI_BASE);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PRI_BASE + ALT_OFS);
    localparam logic [ADDR_W-1:0] SKIP   = ADDR_W'(4);

    always_comb begin
        addr = (alt ? BASE_A : BASE_P) + SKIP + (ADDR_W'(vec) << 1);
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int N      = 54,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int VEC_W  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      irq_set,
    input  logic              cfg_we,
    input  logic [VEC_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [2:0]        cfg_lvl,
    input  logic              ipl_we,
    input  logic [2:0]        ipl_wdata,
    input  logic              nest_dis,
    input  logic              alt_sel,
    input  logic              rfi,
    output logic              take,
    output logic [VEC_W-1:0]  vec_num,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [2:0]        cpu_lvl
);
    import nic_pkg::*;

    localparam int SP_W   = $clog2(DEPTH + 1);
    localparam int STK_IW = $clog2(DEPTH);

    typedef struct packed {
        logic [N-1:0]                 pend;
        lvl_t                         lvl;
        logic [SP_W-1:0]              sp;
        logic [DEPTH-1:0][LVL_W-1:0]  stk;
        logic                         take;
        logic [VEC_W-1:0]             vec;
        logic [ADDR_W-1:0]            addr;
    } state_t;

    state_t s_d, s_q;

    logic [N-1:0]              src_en;
    logic [N-1:0][LVL_W-1:0]   src_lvl;
    logic                      win_valid;
    logic [VEC_W-1:0]          win_idx;
    lvl_t                      win_lvl;
    logic [ADDR_W-1:0]         win_addr;
    logic [STK_IW-1:0]         push_i, pop_i;

    nic_cfg_regs #(.N(N), .VEC_W(VEC_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx),
        .en_in(cfg_en), .lvl_in(cfg_lvl), .en_out(src_en), .lvl_out(src_lvl)
    );

    nic_arbiter #(.N(N), .VEC_W(VEC_W)) u_arb (
        .pend(s_q.pend), .en(src_en), .lvl(src_lvl),
        .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    nic_vec_map #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_map (
        .vec(win_idx), .alt(alt_sel), .addr(win_addr)
    );

    assign push_i = STK_IW'(s_q.sp);
    assign pop_i  = STK_IW'(s_q.sp - SP_W'(1));

    always_comb begin
        logic [N-1:0] clr;
        s_d      = s_q;
        s_d.take = 1'b0;
        clr      = '0;
        if (rfi) begin
            if (s_q.sp != '0) begin
                s_d.sp  = s_q.sp - SP_W'(1);
                s_d.lvl = s_q.stk[pop_i];
            end
        end else if (win_valid && (win_lvl > s_q.lvl) && (s_q.sp < SP_W'(DEPTH))) begin
            s_d.take        = 1'b1;
            s_d.vec         = win_idx;
            s_d.addr        = win_addr;
            s_d.stk[push_i] = s_q.lvl;
            s_d.sp          = s_q.sp + SP_W'(1);
            s_d.lvl         = nest_dis ? LVL_TOP : win_lvl;
            clr[win_idx]    = 1'b1;
        end else if (ipl_we && !nest_dis) begin
            s_d.lvl = ipl_wdata;
        end
        s_d.pend = (s_q.pend & ~clr) | irq_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign take     = s_q.take;
    assign vec_num  = s_q.vec;
    assign vec_addr = s_q.addr;
    assign cpu_lvl  = s_q.lvl;

    assert_take_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.take |-> (s_q.lvl > $past(s_q.lvl)));

    assert_nodest_seven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.take && $past(nest_dis)) |-> (s_q.lvl == LVL_TOP));

    assert_lvl_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nest_dis) && !$past(rfi) && !s_q.take) |-> $stable(s_q.lvl));

    assert_stack_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sp <= SP_W'(DEPTH));

    assert_return_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rfi) |-> !s_q.take);
endmodule

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
    localparam int N = 54;

    logic        clk = 0;
    logic        rst_n;
    logic [N-1:0] irq_set;
    logic        cfg_we, cfg_en, ipl_we, nest_dis, alt_sel, rfi;
    logic [5:0]  cfg_idx;
    logic [2:0]  cfg_lvl, ipl_wdata;
    logic        take;
    logic [5:0]  vec_num;
    logic [15:0] vec_addr;
    logic [2:0]  cpu_lvl;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    nest_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_lvl(cfg_lvl), .ipl_we(ipl_we), .ipl_wdata(ipl_wdata),
        .nest_dis(nest_dis), .alt_sel(alt_sel), .rfi(rfi), .take(take),
        .vec_num(vec_num), .vec_addr(vec_addr), .cpu_lvl(cpu_lvl)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input bit en, input int lvl);
        cfg_we = 1; cfg_idx = 6'(idx); cfg_en = en; cfg_lvl = 3'(lvl);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        irq_set = m;
        @(negedge clk);
        irq_set = '0;
    endtask

    task automatic ret();
        rfi = 1;
        @(negedge clk);
        rfi = 0;
    endtask

    task automatic ipl_write(input int v);
        ipl_we = 1; ipl_wdata = 3'(v);
        @(negedge clk);
        ipl_we = 0;
    endtask

    // Called one cycle after the pulse edge: take is visible at the next negedge.
    task automatic expect_take(input string req, input int v, input int lvl, input bit alt);
        @(negedge clk);
        chk({req, " take"}, int'(take), 1);
        chk({req, " vec"}, int'(vec_num), v);
        chk({req, " addr"}, int'(vec_addr), (alt ? 128 : 0) + 4 + 2 * v);
        chk({req, " lvl"}, int'(cpu_lvl), lvl);
        @(negedge clk);
        chk({req, " single pulse"}, int'(take), 0);
    endtask

    task automatic expect_idle(input string req, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            chk(req, int'(take), 0);
        end
    endtask

    function automatic logic [N-1:0] bit_of(input int i);
        logic [N-1:0] m = '0;
        m[i] = 1'b1;
        return m;
    endfunction

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 0; irq_set = '0; cfg_we = 0; cfg_idx = '0; cfg_en = 0; cfg_lvl = '0;
        ipl_we = 0; ipl_wdata = '0; nest_dis = 0; alt_sel = 0; rfi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state and unconfigured requests
        chk("R1 take after reset", int'(take), 0);
        chk("R1 level after reset", int'(cpu_lvl), 0);
        pulse('1);
        expect_idle("R1 no take before config", 5);
        chk("R1 level unchanged", int'(cpu_lvl), 0);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R3 R5 R8 R10: every source at every level, tables alternating
        for (int v = 0; v < N; v++) begin
            for (int l = 1; l <= 7; l++) begin
                cfg(v, 1, l);
                alt_sel = 1'((v + l) % 2);
                pulse(bit_of(v));
                expect_take("R8 R10 sweep", v, l, alt_sel);
                ret();
                chk("R9 restore after sweep", int'(cpu_lvl), 0);
            end
            cfg(v, 1, 0);
        end
        alt_sel = 0;

        // R8: fixed example values
        cfg(36, 1, 1);
        pulse(bit_of(36));
        @(negedge clk);
        chk("R8 vector 36 primary", int'(vec_addr), 'h4C);
        @(negedge clk); ret();
        alt_sel = 1;
        pulse(bit_of(36));
        @(negedge clk);
        chk("R8 vector 36 alternate", int'(vec_addr), 'hCC);
        @(negedge clk); ret();
        alt_sel = 0;
        cfg(36, 1, 0);

        // R10: no retake without a new request
        cfg(9, 1, 3);
        pulse(bit_of(9));
        expect_take("R10 first", 9, 3, 0);
        ret();
        expect_idle("R10 no retake", 3);
        cfg(9, 1, 0);

        // R2: level 0 and disabled sources stay pending but untaken
        cfg(5, 1, 0);
        cfg(6, 0, 4);
        pulse(bit_of(5) | bit_of(6));
        expect_idle("R2 ineligible", 4);
        chk("R2 level", int'(cpu_lvl), 0);
        cfg(6, 1, 4);
        expect_take("R2 enabled later", 6, 4, 0);
        ret();
        cfg(5, 1, 3);
        expect_take("R2 level set later", 5, 3, 0);
        ret();
        cfg(5, 1, 0); cfg(6, 1, 0);

        // R4: every pair at equal level, lower vector first
        for (int i = 0; i < N - 1; i++) begin
            for (int j = i + 1; j < N; j++) begin
                int l;
                l = ((i + j) % 7) + 1;
                cfg(i, 1, l); cfg(j, 1, l);
                pulse(bit_of(i) | bit_of(j));
                expect_take("R4 tie first", i, l, 0);
                chk("R4 tie blocks equal", int'(take), 0);
                ret();
                expect_take("R4 tie second", j, l, 0);
                ret();
                cfg(i, 1, 0); cfg(j, 1, 0);
            end
        end

        // R3: higher level beats lower vector number
        for (int i = 0; i < N / 2; i++) begin
            int j, li;
            j  = N - 1 - i;
            li = (i % 6) + 1;
            cfg(i, 1, li); cfg(j, 1, li + 1);
            pulse(bit_of(i) | bit_of(j));
            expect_take("R3 level override", j, li + 1, 0);
            ret();
            expect_take("R3 lower after return", i, li, 0);
            ret();
            cfg(i, 1, 0); cfg(j, 1, 0);
        end

        // R5 R9: nesting rules
        cfg(10, 1, 2); cfg(11, 1, 2); cfg(12, 1, 5);
        pulse(bit_of(10));
        expect_take("R5 base", 10, 2, 0);
        pulse(bit_of(11));
        expect_idle("R5 equal level no preempt", 3);
        pulse(bit_of(12));
        expect_take("R5 higher preempts", 12, 5, 0);
        ret();
        chk("R9 pop to 2", int'(cpu_lvl), 2);
        expect_idle("R5 equal still blocked", 2);
        ret();
        expect_take("R5 pending after return", 11, 2, 0);
        ret();
        chk("R9 pop to 0", int'(cpu_lvl), 0);
        ret();
        chk("R9 empty return", int'(cpu_lvl), 0);
        ipl_write(4);
        chk("R7 write loads", int'(cpu_lvl), 4);
        ret();
        chk("R9 empty return keeps written", int'(cpu_lvl), 4);
        ipl_write(0);
        cfg(10, 1, 0); cfg(11, 1, 0); cfg(12, 1, 0);

        // R6 R7: nesting disabled
        nest_dis = 1;
        cfg(20, 1, 1); cfg(21, 1, 6);
        pulse(bit_of(20));
        expect_take("R6 forced seven", 20, 7, 0);
        pulse(bit_of(21));
        expect_idle("R6 no nesting", 3);
        ipl_write(0);
        chk("R7 locked write", int'(cpu_lvl), 7);
        expect_idle("R7 still masked", 2);
        ret();
        expect_take("R6 after return", 21, 7, 0);
        ret();
        ipl_write(3);
        chk("R7 locked at zero", int'(cpu_lvl), 0);
        cfg(22, 1, 2); cfg(23, 1, 5);
        pulse(bit_of(22) | bit_of(23));
        expect_take("R6 levels arbitrate", 23, 7, 0);
        ret();
        expect_take("R6 second", 22, 7, 0);
        ret();
        nest_dis = 0;
        ipl_write(3);
        chk("R7 unlocked write", int'(cpu_lvl), 3);
        ipl_write(0);
        cfg(20, 1, 0); cfg(21, 1, 0); cfg(22, 1, 0); cfg(23, 1, 0);

        // R11: return and take in the same cycle
        cfg(30, 1, 3); cfg(31, 1, 2); cfg(32, 1, 6);
        pulse(bit_of(30));
        expect_take("R11 setup", 30, 3, 0);
        pulse(bit_of(31));
        irq_set = bit_of(32);
        @(negedge clk);
        irq_set = '0;
        rfi = 1;
        @(negedge clk);
        rfi = 0;
        chk("R11 no take with return", int'(take), 0);
        chk("R11 level restored", int'(cpu_lvl), 0);
        expect_take("R11 take next cycle", 32, 6, 0);
        ret();
        expect_take("R11 remaining", 31, 2, 0);
        ret();
        cfg(30, 1, 0); cfg(31, 1, 0); cfg(32, 1, 0);

        // R12: level write and take in the same cycle
        cfg(40, 1, 4);
        pulse(bit_of(40));
        ipl_we = 1; ipl_wdata = 3'd1;
        @(negedge clk);
        ipl_we = 0;
        chk("R12 take", int'(take), 1);
        chk("R12 level is winner", int'(cpu_lvl), 4);
        ret();
        chk("R12 pushed old level", int'(cpu_lvl), 0);
        cfg(40, 1, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule